// File: doc/BRIEF.md
# Single-Cycle Register-Machine Core

This block is a small processor core that retires one instruction on every clock edge. In one cycle it reads an instruction word from a unified instruction/data memory, splits it into fields, selects two operands, computes a result or an effective address, and writes the outcome back to a register, to memory or to the program counter. The core has five operations: add, subtract, load, store and halt. It has no separate program-counter path and no separate immediate path. Instead, three register numbers carry fixed meanings. Register 0 reads as zero, and a write to it sends out a character. Register 30 yields the instruction's literal. Register 31 is the address of the next instruction, and writing it is the only form of jump.

A host fills memory through a simple write port while reset is held. After reset is released, execution starts from byte address 0. The host observes the run through a character strobe and two status flags: halted and illegal.

The control is a four-state machine:
- ST_LOAD is held while reset is asserted. It is the only state in which host writes reach memory.
- ST_LOAD moves to ST_RUN on the first clock edge after reset is released. No instruction executes on that edge.
- ST_RUN executes one instruction per edge.
- ST_RUN moves to ST_HALT on a halt opcode.
- ST_RUN moves to ST_FAULT on an undefined opcode.
- ST_HALT and ST_FAULT hold until reset returns the machine to ST_LOAD.

Top module: `scp_core`

## Requirements
- R1: An instruction word is decoded as follows:
  - opcode in bits 31:29, where 0 is halt, 1 is add, 2 is subtract, 3 is load and 4 is store;
  - destination register in bits 28:24;
  - source A in bits 23:19;
  - source B in bits 18:14;
  - a 14-bit two's-complement literal in bits 13:0.
- R2: While `rst` is high:
  - `halted`, `illegal` and `char_valid` are 0;
  - general registers are cleared;
  - `host_we` writes `host_data` to memory word `host_addr`.

  When `rst` is low, `host_we` has no effect. The first instruction executed after release is the word at byte address 0, on the second rising edge after release.
- R3: Add writes srcA + srcB, and subtract writes srcA − srcB, to the destination register, modulo 2^32.
- R4: Register 0 always reads as 0. An add, subtract or load whose destination is 0 leaves it at 0. Instead, it sets `char_data` to bits 7:0 of the result and raises `char_valid` for exactly the one cycle after that instruction's edge.
- R5: Register 30 as a source yields the sign-extended literal of the current instruction. Writes to register 30 are discarded.
- R6: Register 31 as a source yields the current instruction's byte address plus 4. Writing register 31 sets the byte address of the next instruction fetched.
- R7: A load writes the destination register with the memory word at byte address srcA + 4 × srcB.
- R8: A store writes the value read through the destination field to byte address srcA + 4 × srcB. The destination field follows the same special-register rules as a source.
- R9: A halt raises `halted`. After it, no further instruction executes and no character is emitted until `rst`.
- R10: Opcodes 5, 6 and 7 stop the core as a halt does, and also raise `illegal`.
- R11: A byte address selects memory word address[9:2]. Address bits 1:0 and all bits above bit 9 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; also enables host preload |
| host_we | input | 1 | Host memory write enable, effective only during reset |
| host_addr | input | 8 | Host write word index |
| host_data | input | 32 | Host write data |
| char_valid | output | 1 | One-cycle strobe for an emitted character |
| char_data | output | 8 | Emitted character |
| halted | output | 1 | Core has stopped (halt or illegal opcode) |
| illegal | output | 1 | Core stopped on an undefined opcode |

## Verification
Each scenario loads a short program during reset and compares the emitted character stream and the final flags against values worked out from the requirements.

- Arithmetic programs mix positive, negative and wrapping operands, which separates add from subtract and shows sign extension of the literal in the low byte.
- Programs that read and write register 31 tell the "current address plus 4" rule from an off-by-one fetch address. They also show that forward and backward jumps both redirect fetch.
- Memory programs load host-preloaded data, store and reload, store the literal through the destination field, and use unaligned and wrapped addresses. Together these tell the scaled-index address rule from a plain sum, and show that bits outside the word index are ignored.
- Halt, illegal-opcode and reset-rerun programs check that nothing executes after a stop. They also check that a host write made outside reset is ignored.

// File: rtl/scp_pkg.sv
package scp_pkg;

    localparam int LIT_W     = 14;
    localparam int REG_IDX_W = 5;
    localparam int REG_NUM   = 1 << REG_IDX_W;
    localparam int INSTR_W   = 32;

    // register numbers with fixed meaning
    localparam logic [REG_IDX_W-1:0] REG_ZERO = REG_IDX_W'(0);
    localparam logic [REG_IDX_W-1:0] REG_LIT  = REG_IDX_W'(REG_NUM - 2);
    localparam logic [REG_IDX_W-1:0] REG_PC   = REG_IDX_W'(REG_NUM - 1);

    // opcode values
    localparam logic [2:0] OPC_HALT  = 3'd0;
    localparam logic [2:0] OPC_ADD   = 3'd1;
    localparam logic [2:0] OPC_SUB   = 3'd2;
    localparam logic [2:0] OPC_LOAD  = 3'd3;
    localparam logic [2:0] OPC_STORE = 3'd4;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_RUN   = 2'd1,
        ST_HALT  = 2'd2,
        ST_FAULT = 2'd3
    } core_state_e;

    typedef struct packed {
        logic [2:0]           opc;
        logic [REG_IDX_W-1:0] dst;
        logic [REG_IDX_W-1:0] src_a;
        logic [REG_IDX_W-1:0] src_b;
        logic [LIT_W-1:0]     lit;
    } instr_t;

endpackage

// File: rtl/scp_decode.sv
module scp_decode
    import scp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [INSTR_W-1:0] word,
    output instr_t             ins,
    output logic [DATA_W-1:0]  lit_ext,
    output logic               op_legal,
    output logic               op_writes_reg,
    output logic               op_store,
    output logic               op_halt
);

    always_comb begin
        ins.opc   = word[31:29];
        ins.dst   = word[28:24];
        ins.src_a = word[23:19];
        ins.src_b = word[18:14];
        ins.lit   = word[LIT_W-1:0];

        lit_ext = {{(DATA_W - LIT_W){word[LIT_W-1]}}, word[LIT_W-1:0]};

        op_legal      = (word[31:29] <= OPC_STORE);
        op_writes_reg = (word[31:29] == OPC_ADD) || (word[31:29] == OPC_SUB) ||
                        (word[31:29] == OPC_LOAD);
        op_store      = (word[31:29] == OPC_STORE);
        op_halt       = (word[31:29] == OPC_HALT);
    end

endmodule

// File: rtl/scp_regfile.sv
module scp_regfile
    import scp_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int RD_PORTS = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [REG_IDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [REG_IDX_W-1:0] rd_idx [RD_PORTS],
    input  logic [DATA_W-1:0]    lit_val,
    input  logic [DATA_W-1:0]    next_pc,
    output logic [DATA_W-1:0]    rd_data [RD_PORTS]
);

    logic [DATA_W-1:0] store_q [REG_NUM];
    logic              wr_ok;

    // the three special numbers have no storage behind them
    assign wr_ok = we && (wr_idx != REG_ZERO) && (wr_idx != REG_LIT) && (wr_idx != REG_PC);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_NUM; i++) begin
                store_q[i] <= '0;
            end
        end else if (wr_ok) begin
            store_q[wr_idx] <= wr_data;
        end
    end

    generate
        for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
            logic [DATA_W-1:0] val;
            always_comb begin
                if (rd_idx[p] == REG_ZERO) begin
                    val = '0;
                end else if (rd_idx[p] == REG_LIT) begin
                    val = lit_val;
                end else if (rd_idx[p] == REG_PC) begin
                    val = next_pc;
                end else begin
                    val = store_q[rd_idx[p]];
                end
            end
            assign rd_data[p] = val;
        end
    endgenerate

endmodule

// File: rtl/scp_exec.sv
module scp_exec
    import scp_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int MEM_WORDS = 256,
    localparam int MEM_IDX_W = $clog2(MEM_WORDS)
) (
    input  logic [2:0]           opc,
    input  logic [DATA_W-1:0]    opnd_a,
    input  logic [DATA_W-1:0]    opnd_b,
    input  logic [DATA_W-1:0]    load_word,
    output logic [DATA_W-1:0]    result,
    output logic [MEM_IDX_W-1:0] word_idx
);

    logic [DATA_W-1:0] eff_addr;
    logic              unused_addr_bits;

    always_comb begin
        eff_addr = opnd_a + {opnd_b[DATA_W-3:0], 2'b00};
        word_idx = eff_addr[MEM_IDX_W+1:2];
        unique case (opc)
            OPC_SUB:  result = opnd_a - opnd_b;
            OPC_LOAD: result = load_word;
            default:  result = opnd_a + opnd_b;
        endcase
    end

    assign unused_addr_bits = ^{eff_addr[DATA_W-1:MEM_IDX_W+2], eff_addr[1:0], opnd_b[DATA_W-1:DATA_W-2]};

endmodule

// File: rtl/scp_memory.sv
module scp_memory #(
    parameter int DATA_W    = 32,
    parameter int MEM_WORDS = 256,
    localparam int MEM_IDX_W = $clog2(MEM_WORDS)
) (
    input  logic                 clk,
    input  logic [MEM_IDX_W-1:0] fetch_idx,
    output logic [DATA_W-1:0]    fetch_word,
    input  logic [MEM_IDX_W-1:0] data_idx,
    output logic [DATA_W-1:0]    data_word,
    input  logic                 we,
    input  logic [MEM_IDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0]    wr_data
);

    logic [DATA_W-1:0] cells [MEM_WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[wr_idx] <= wr_data;
        end
    end

    assign fetch_word = cells[fetch_idx];
    assign data_word  = cells[data_idx];

endmodule

// File: rtl/scp_core.sv
module scp_core
    import scp_pkg::*;
#(
    parameter int MEM_WORDS = 256,
    parameter int DATA_W    = 32,
    localparam int MEM_IDX_W = $clog2(MEM_WORDS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 host_we,
    input  logic [MEM_IDX_W-1:0] host_addr,
    input  logic [DATA_W-1:0]    host_data,
    output logic                 char_valid,
    output logic [7:0]           char_data,
    output logic                 halted,
    output logic                 illegal
);

    localparam int RD_PORTS = 3;

    core_state_e state_q, state_d;

    logic [DATA_W-1:0]    pc_q;
    logic [DATA_W-1:0]    next_pc;
    logic [DATA_W-1:0]    fetch_word;
    logic [DATA_W-1:0]    data_word;
    logic [DATA_W-1:0]    lit_ext;
    logic [DATA_W-1:0]    result;
    logic [MEM_IDX_W-1:0] data_idx;
    instr_t               ins;
    logic                 op_legal, op_writes_reg, op_store, op_halt;
    logic                 run, do_wb, do_store, emit, pc_redirect;
    logic [REG_IDX_W-1:0] rd_idx  [RD_PORTS];
    logic [DATA_W-1:0]    rd_data [RD_PORTS];
    logic                 mem_we;
    logic [MEM_IDX_W-1:0] mem_wr_idx;
    logic [DATA_W-1:0]    mem_wr_data;

    assign next_pc = pc_q + DATA_W'(4);

    // ---------------------------------------------------------------- fetch
    scp_memory #(.DATA_W(DATA_W), .MEM_WORDS(MEM_WORDS)) u_mem (
        .clk        (clk),
        .fetch_idx  (pc_q[MEM_IDX_W+1:2]),
        .fetch_word (fetch_word),
        .data_idx   (data_idx),
        .data_word  (data_word),
        .we         (mem_we),
        .wr_idx     (mem_wr_idx),
        .wr_data    (mem_wr_data)
    );

    // --------------------------------------------------------------- decode
    scp_decode #(.DATA_W(DATA_W)) u_dec (
        .word          (fetch_word),
        .ins           (ins),
        .lit_ext       (lit_ext),
        .op_legal      (op_legal),
        .op_writes_reg (op_writes_reg),
        .op_store      (op_store),
        .op_halt       (op_halt)
    );

    // ------------------------------------------------------- operand select
    assign rd_idx[0] = ins.src_a;
    assign rd_idx[1] = ins.src_b;
    assign rd_idx[2] = ins.dst;

    scp_regfile #(.DATA_W(DATA_W), .RD_PORTS(RD_PORTS)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (do_wb),
        .wr_idx  (ins.dst),
        .wr_data (result),
        .rd_idx  (rd_idx),
        .lit_val (lit_ext),
        .next_pc (next_pc),
        .rd_data (rd_data)
    );

    // -------------------------------------------------------------- execute
    scp_exec #(.DATA_W(DATA_W), .MEM_WORDS(MEM_WORDS)) u_exec (
        .opc       (ins.opc),
        .opnd_a    (rd_data[0]),
        .opnd_b    (rd_data[1]),
        .load_word (data_word),
        .result    (result),
        .word_idx  (data_idx)
    );

    // ------------------------------------------------------------ writeback
    assign run         = (state_q == ST_RUN);
    assign do_wb       = run && op_writes_reg;
    assign do_store    = run && op_store;
    assign emit        = do_wb && (ins.dst == REG_ZERO);
    assign pc_redirect = do_wb && (ins.dst == REG_PC);

    // the host owns the write port for as long as reset is held
    always_comb begin
        if (rst) begin
            mem_we      = host_we;
            mem_wr_idx  = host_addr;
            mem_wr_data = host_data;
        end else begin
            mem_we      = do_store;
            mem_wr_idx  = data_idx;
            mem_wr_data = rd_data[2];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (run) begin
            pc_q <= pc_redirect ? result : next_pc;
        end
    end

    // ------------------------------------------------------- state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:  state_d = ST_RUN;
            ST_RUN: begin
                if (!op_legal) begin
                    state_d = ST_FAULT;
                end else if (op_halt) begin
                    state_d = ST_HALT;
                end
            end
            ST_HALT:  state_d = ST_HALT;
            ST_FAULT: state_d = ST_FAULT;
        endcase
    end

    // -------------------------------------------------------------- outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            char_valid <= 1'b0;
            char_data  <= '0;
        end else begin
            char_valid <= emit;
            if (emit) begin
                char_data <= result[7:0];
            end
        end
    end

    always_comb begin
        halted  = (state_q == ST_HALT) || (state_q == ST_FAULT);
        illegal = (state_q == ST_FAULT);
    end

endmodule

// File: rtl/scp_core_chk.sv
module scp_core_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              char_valid,
    input logic              halted,
    input logic              illegal,
    input logic [DATA_W-1:0] pc_q
);

    // R9
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R9
    halt_pc_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(pc_q));

    // R9
    halt_silent_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> !char_valid);

    // R10
    illegal_implies_halt_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> halted);

    // R10
    illegal_rises_with_halt_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(illegal) |-> $rose(halted));

    // R2
    reset_release_clean_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc_q == '0 && !halted && !char_valid));

endmodule

bind scp_core scp_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .char_valid (char_valid),
    .halted     (halted),
    .illegal    (illegal),
    .pc_q       (pc_q)
);

// File: tb/scp_core_test.sv
module scp_core_test;

    localparam int MEM_WORDS = 256;
    localparam int DATA_W    = 32;

    localparam logic [2:0] OP_HLT = 3'd0;
    localparam logic [2:0] OP_ADD = 3'd1;
    localparam logic [2:0] OP_SUB = 3'd2;
    localparam logic [2:0] OP_LD  = 3'd3;
    localparam logic [2:0] OP_ST  = 3'd4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_data = '0;
    logic        char_valid;
    logic [7:0]  char_data;
    logic        halted;
    logic        illegal;

    scp_core #(.MEM_WORDS(MEM_WORDS), .DATA_W(DATA_W)) uut (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_data  (host_data),
        .char_valid (char_valid),
        .char_data  (char_data),
        .halted     (halted),
        .illegal    (illegal)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    // character monitor: one entry per cycle in which the strobe is high
    logic [7:0] seen [256];
    int         n_seen = 0;
    always @(negedge clk) begin
        if (!rst && char_valid) begin
            if (n_seen < 256) seen[n_seen] = char_data;
            n_seen = n_seen + 1;
        end
    end

    logic [31:0] prog [32];
    int          prog_n;
    logic [7:0]  want [16];
    int          want_n;
    int          base;

    // R1 field layout: opcode 31:29, dst 28:24, srcA 23:19, srcB 18:14, literal 13:0
    function automatic logic [31:0] enc(input logic [2:0] op, input int d, input int a,
                                        input int b, input int lit);
        return {op, 5'(d), 5'(a), 5'(b), 14'(lit)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic enter_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
    endtask

    task automatic poke(input int idx, input logic [31:0] val);
        host_we   = 1'b1;
        host_addr = 8'(idx);
        host_data = val;
        @(negedge clk);
        host_we   = 1'b0;
    endtask

    task automatic load_prog();
        for (int i = 0; i < prog_n; i++) poke(i, prog[i]);
    endtask

    task automatic release_and_run(input string req);
        int cyc;
        base = n_seen;
        rst  = 1'b0;
        cyc  = 0;
        while (!halted && cyc < 300) begin
            @(negedge clk);
            cyc++;
        end
        check({req, " run reaches halt"}, 32'(halted), 32'd1);
    endtask

    task automatic expect_chars(input string req);
        check({req, " char count"}, 32'(n_seen - base), 32'(want_n));
        for (int i = 0; i < want_n && i < n_seen - base; i++) begin
            check({req, " char value"}, 32'(seen[base + i]), 32'(want[i]));
        end
    endtask

    // R2: reset state, preload, start at address 0, host writes outside reset ignored
    task automatic t_reset();
        enter_reset();
        @(negedge clk);
        check("R2 halted in reset", 32'(halted), 32'd0);
        check("R2 illegal in reset", 32'(illegal), 32'd0);
        check("R2 char_valid in reset", 32'(char_valid), 32'd0);
        prog[0] = enc(OP_ADD, 0, 30, 0, 83);       // emit 'S'
        prog[1] = enc(OP_LD, 5, 0, 30, 40);        // r5 = mem[160] = word 40
        prog[2] = enc(OP_ADD, 0, 5, 0, 0);
        prog[3] = enc(OP_HLT, 0, 0, 0, 0);
        prog_n  = 4;
        load_prog();
        poke(40, 32'h0000_0041);
        release_and_run("R2");
        want[0] = 8'h53; want[1] = 8'h41; want_n = 2;
        expect_chars("R2 start at 0");
        // host write while running is ignored
        @(negedge clk);
        poke(40, 32'h0000_0099);
        enter_reset();
        check("R2 halted cleared by reset", 32'(halted), 32'd0);
        release_and_run("R2");
        expect_chars("R2 host write outside reset ignored");
    endtask

    // R3, R4: arithmetic and wrap
    task automatic t_arith();
        enter_reset();
        prog[0] = enc(OP_ADD, 1, 30, 30, 5);       // r1 = 10
        prog[1] = enc(OP_ADD, 0, 1, 0, 0);         // emit 10
        prog[2] = enc(OP_SUB, 2, 1, 30, 3);        // r2 = 7
        prog[3] = enc(OP_ADD, 0, 2, 0, 0);         // emit 7
        prog[4] = enc(OP_ADD, 0, 30, 0, -1);       // emit FF
        prog[5] = enc(OP_SUB, 3, 0, 30, 2);        // r3 = -2
        prog[6] = enc(OP_ADD, 0, 3, 30, 3);        // emit 1
        prog[7] = enc(OP_HLT, 0, 0, 0, 0);
        prog_n  = 8;
        load_prog();
        release_and_run("R3");
        want[0] = 8'd10; want[1] = 8'd7; want[2] = 8'hFF; want[3] = 8'd1; want_n = 4;
        expect_chars("R3 add/sub");
    endtask

    // R4, R5: zero register and literal register
    task automatic t_special_regs();
        enter_reset();
        prog[0] = enc(OP_ADD, 0, 30, 0, 9);        // emit 9
        prog[1] = enc(OP_ADD, 0, 0, 30, 1);        // r0 still 0 -> emit 1
        prog[2] = enc(OP_ADD, 30, 30, 30, 7);      // discarded
        prog[3] = enc(OP_ADD, 0, 30, 0, 3);        // emit 3
        prog[4] = enc(OP_ADD, 0, 30, 30, 8191);    // 2*8191 = 3FFE -> FE
        prog[5] = enc(OP_HLT, 0, 0, 0, 0);
        prog_n  = 6;
        load_prog();
        release_and_run("R4");
        want[0] = 8'd9; want[1] = 8'd1; want[2] = 8'd3; want[3] = 8'hFE; want_n = 4;
        expect_chars("R4 R5 special registers");
        check("R4 strobe low after halt", 32'(char_valid), 32'd0);
    endtask

    // R6: reading and writing the next-instruction register
    task automatic t_pc();
        enter_reset();
        prog[0] = enc(OP_ADD, 0, 31, 0, 0);        // emit 4
        prog[1] = enc(OP_ADD, 0, 31, 0, 0);        // emit 8
        prog[2] = enc(OP_SUB, 0, 31, 30, 4);       // 12-4 = 8
        prog[3] = enc(OP_ADD, 31, 30, 0, 24);      // jump to word 6
        prog[4] = enc(OP_ADD, 0, 30, 0, 88);       // skipped
        prog[5] = enc(OP_HLT, 0, 0, 0, 0);
        prog[6] = enc(OP_ADD, 0, 30, 0, 65);       // emit 'A'
        prog[7] = enc(OP_SUB, 31, 31, 30, 12);     // 32-12 = 20 -> word 5
        prog[8] = enc(OP_ADD, 0, 30, 0, 90);       // skipped
        prog_n  = 9;
        load_prog();
        release_and_run("R6");
        want[0] = 8'd4; want[1] = 8'd8; want[2] = 8'd8; want[3] = 8'h41; want_n = 4;
        expect_chars("R6 pc read and jumps");
    endtask

    // R7, R8, R11: load, store, address forming
    task automatic t_mem();
        enter_reset();
        prog[0]  = enc(OP_ADD, 1, 30, 0, 40);      // r1 = 40
        prog[1]  = enc(OP_LD, 5, 0, 1, 0);         // mem[160] word 40
        prog[2]  = enc(OP_ADD, 0, 5, 0, 0);        // emit 41
        prog[3]  = enc(OP_ADD, 2, 30, 0, 90);      // r2 = 5A
        prog[4]  = enc(OP_ADD, 3, 30, 0, 200);     // r3 = 200
        prog[5]  = enc(OP_ST, 2, 3, 30, 2);        // mem[208] = 5A
        prog[6]  = enc(OP_LD, 4, 3, 30, 2);
        prog[7]  = enc(OP_ADD, 0, 4, 0, 0);        // emit 5A
        prog[8]  = enc(OP_ST, 30, 0, 30, 51);      // mem[204] = 51 (0x33)
        prog[9]  = enc(OP_LD, 6, 0, 30, 51);
        prog[10] = enc(OP_ADD, 0, 6, 0, 0);        // emit 33
        prog[11] = enc(OP_LD, 7, 30, 0, 162);      // unaligned -> word 40
        prog[12] = enc(OP_ADD, 0, 7, 0, 0);        // emit 41
        prog[13] = enc(OP_LD, 8, 30, 0, 1184);     // 1024+160 wraps -> word 40
        prog[14] = enc(OP_ADD, 0, 8, 0, 0);        // emit 41
        prog[15] = enc(OP_LD, 0, 0, 1, 0);         // load into r0 emits 41
        prog[16] = enc(OP_HLT, 0, 0, 0, 0);
        prog_n   = 17;
        load_prog();
        poke(40, 32'h1234_5641);
        release_and_run("R7");
        want[0] = 8'h41; want[1] = 8'h5A; want[2] = 8'h33; want[3] = 8'h41;
        want[4] = 8'h41; want[5] = 8'h41; want_n = 6;
        expect_chars("R7 R8 R11 memory");
    endtask

    // R9: halt stops everything
    task automatic t_halt();
        enter_reset();
        prog[0] = enc(OP_ADD, 0, 30, 0, 75);       // emit 'K'
        prog[1] = enc(OP_HLT, 0, 0, 0, 0);
        prog[2] = enc(OP_ADD, 0, 30, 0, 90);
        prog[3] = enc(OP_ADD, 31, 0, 0, 0);
        prog_n  = 4;
        load_prog();
        release_and_run("R9");
        repeat (20) @(negedge clk);
        want[0] = 8'h4B; want_n = 1;
        expect_chars("R9 nothing after halt");
        check("R9 halted stays", 32'(halted), 32'd1);
        check("R9 not illegal", 32'(illegal), 32'd0);
    endtask

    // R10, R1: undefined opcodes
    task automatic t_illegal(input logic [2:0] op);
        enter_reset();
        prog[0] = enc(OP_ADD, 0, 30, 0, 73);       // emit 'I'
        prog[1] = enc(op, 0, 0, 0, 0);
        prog[2] = enc(OP_ADD, 0, 30, 0, 90);
        prog[3] = enc(OP_HLT, 0, 0, 0, 0);
        prog_n  = 4;
        load_prog();
        release_and_run("R10");
        repeat (5) @(negedge clk);
        want[0] = 8'h49; want_n = 1;
        expect_chars("R10 R1 nothing after illegal");
        check("R10 illegal flag", 32'(illegal), 32'd1);
        check("R10 halted flag", 32'(halted), 32'd1);
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_arith();
        t_special_regs();
        t_pc();
        t_mem();
        t_halt();
        t_illegal(3'd5);
        t_illegal(3'd7);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule